// File: doc/BRIEF.md
# Masked Condition Flag Generator

This combinational block produces the updated status-flag word that follows an integer ALU micro-operation. The caller supplies the previous flag word, a per-bit update mask, the operation's result, both source operands and a two-bit operand-size code. The block does not perform the arithmetic. It inspects the operands and the result at the selected size and rewrites only the flags that the mask selects.

Six architectural flags are covered: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. Two microcode-internal flags are also covered. One copies the carry rule and the other copies the zero rule, and each has its own mask bit. Carry and overflow follow the addition convention. Subtraction borrow is not modelled. The block holds no state, so the new word is valid in the same cycle as its inputs.

Top module: `flag_gen`

## Requirements
- R1: Every bit of `newFlags` whose `flagMask` bit is 0 equals the same bit of `oldFlags`.
- R2: Every bit whose mask bit is 1 is first cleared and is then set only if its flag condition holds. Flag positions are carry 0, parity 2, aux carry 4, zero 6, sign 7, overflow 11, emulation carry 16 and emulation zero 17. A masked bit at any other position reads 0.
- R3: Carry is `(a&b)|((a|b)&~d)`, taken at the top bit of the operand size, where a and b are the source bits and d is the result bit.
- R4: Aux carry applies the same carry rule at bit 3, which is the carry out of the low nibble.
- R5: Parity is 1 when `result[7:0]` holds an even number of ones, for every operand size.
- R6: Zero is 1 when the result bits below the operand-size boundary are all 0.
- R7: Sign equals the result bit at the top of the operand size.
- R8: Overflow is 1 when both sources have the same top bit and the result's top bit differs from it.
- R9: Emulation carry follows the carry rule and emulation zero follows the zero rule. Each one is gated only by its own mask bit.
- R10: The size code maps 0 to 1 byte, 1 to 2 bytes, 2 to 4 bytes and 3 to 8 bytes. Result and source bits above the selected size do not affect any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oldFlags | input | 64 | Flag word before the operation |
| flagMask | input | 64 | Per-bit update enable |
| result | input | 64 | Result of the ALU operation |
| src1 | input | 64 | First source operand |
| src2 | input | 64 | Second source operand |
| sizeCode | input | 2 | Operand-size code |
| newFlags | output | 64 | Updated flag word |

## Verification
The bench uses the default 64-bit data and flag widths with the default flag positions. At these widths all four operand sizes are reachable, including the full 8-byte lane, whose zero and sign tests use the very top bit. Directed cases exercise boundary sums such as 0xFF+1 and 0x7F+1 at different sizes, so that carry, nibble carry, overflow and truncated-zero appear at each lane edge. Random operands, masks and old words then run against a bench reference model. Half of these use real sums and half use unrelated results.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;
  localparam int NUM_SIZES = 4;

  typedef struct packed {
    logic [NUM_SIZES-1:0] sizeSel;
    logic updCf;
    logic updPf;
    logic updAf;
    logic updZf;
    logic updSf;
    logic updOf;
    logic updEcf;
    logic updEzf;
  } flagStrobes_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_gen_pkg::*;
#(
  parameter int FLAG_W  = 64,
  parameter int CF_POS  = 0,
  parameter int PF_POS  = 2,
  parameter int AF_POS  = 4,
  parameter int ZF_POS  = 6,
  parameter int SF_POS  = 7,
  parameter int OF_POS  = 11,
  parameter int ECF_POS = 16,
  parameter int EZF_POS = 17
) (
  input  logic [1:0]        sizeCode,
  input  logic [FLAG_W-1:0] flagMask,
  output flagStrobes_t      strobes
);
  always_comb begin
    strobes.sizeSel = '0;
    strobes.sizeSel[sizeCode] = 1'b1;
    strobes.updCf  = flagMask[CF_POS];
    strobes.updPf  = flagMask[PF_POS];
    strobes.updAf  = flagMask[AF_POS];
    strobes.updZf  = flagMask[ZF_POS];
    strobes.updSf  = flagMask[SF_POS];
    strobes.updOf  = flagMask[OF_POS];
    strobes.updEcf = flagMask[ECF_POS];
    strobes.updEzf = flagMask[EZF_POS];
  end
endmodule

// File: rtl/flag_calc.sv
module flag_calc
  import flag_gen_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int FLAG_W  = 64,
  parameter int CF_POS  = 0,
  parameter int PF_POS  = 2,
  parameter int AF_POS  = 4,
  parameter int ZF_POS  = 6,
  parameter int SF_POS  = 7,
  parameter int OF_POS  = 11,
  parameter int ECF_POS = 16,
  parameter int EZF_POS = 17
) (
  input  logic [FLAG_W-1:0] oldFlags,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  flagStrobes_t      strobes,
  output logic [FLAG_W-1:0] newFlags
);
  localparam int NIB_TOP = 3;

  logic [NUM_SIZES-1:0] laneTopD, laneTopA, laneTopB, laneZero;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : gLane
    localparam int LW = 8 << g;
    assign laneTopD[g] = result[LW-1];
    assign laneTopA[g] = src1[LW-1];
    assign laneTopB[g] = src2[LW-1];
    assign laneZero[g] = ~|result[LW-1:0];
  end

  logic topD, topA, topB, isZero, carryTop, nibCarry, oddLow, overflow;

  always_comb begin
    topD     = |(laneTopD & strobes.sizeSel);
    topA     = |(laneTopA & strobes.sizeSel);
    topB     = |(laneTopB & strobes.sizeSel);
    isZero   = |(laneZero & strobes.sizeSel);
    carryTop = (topA & topB) | ((topA | topB) & ~topD);
    nibCarry = (src1[NIB_TOP] & src2[NIB_TOP]) |
               ((src1[NIB_TOP] | src2[NIB_TOP]) & ~result[NIB_TOP]);
    oddLow   = ^result[7:0];
    overflow = (topA == topB) && (topD != topA);
  end

  always_comb begin
    newFlags = oldFlags & ~flagMask;
    if (strobes.updCf  && carryTop) newFlags[CF_POS]  = 1'b1;
    if (strobes.updPf  && !oddLow)  newFlags[PF_POS]  = 1'b1;
    if (strobes.updAf  && nibCarry) newFlags[AF_POS]  = 1'b1;
    if (strobes.updZf  && isZero)   newFlags[ZF_POS]  = 1'b1;
    if (strobes.updSf  && topD)     newFlags[SF_POS]  = 1'b1;
    if (strobes.updOf  && overflow) newFlags[OF_POS]  = 1'b1;
    if (strobes.updEcf && carryTop) newFlags[ECF_POS] = 1'b1;
    if (strobes.updEzf && isZero)   newFlags[EZF_POS] = 1'b1;
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import flag_gen_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int FLAG_W  = 64,
  parameter int CF_POS  = 0,
  parameter int PF_POS  = 2,
  parameter int AF_POS  = 4,
  parameter int ZF_POS  = 6,
  parameter int SF_POS  = 7,
  parameter int OF_POS  = 11,
  parameter int ECF_POS = 16,
  parameter int EZF_POS = 17
) (
  input  logic [FLAG_W-1:0] oldFlags,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [1:0]        sizeCode,
  output logic [FLAG_W-1:0] newFlags
);
  flagStrobes_t strobes;

  flag_ctrl #(
    .FLAG_W(FLAG_W), .CF_POS(CF_POS), .PF_POS(PF_POS), .AF_POS(AF_POS),
    .ZF_POS(ZF_POS), .SF_POS(SF_POS), .OF_POS(OF_POS),
    .ECF_POS(ECF_POS), .EZF_POS(EZF_POS)
  ) uCtrl (
    .sizeCode(sizeCode),
    .flagMask(flagMask),
    .strobes(strobes)
  );

  flag_calc #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .CF_POS(CF_POS), .PF_POS(PF_POS),
    .AF_POS(AF_POS), .ZF_POS(ZF_POS), .SF_POS(SF_POS), .OF_POS(OF_POS),
    .ECF_POS(ECF_POS), .EZF_POS(EZF_POS)
  ) uCalc (
    .oldFlags(oldFlags),
    .flagMask(flagMask),
    .result(result),
    .src1(src1),
    .src2(src2),
    .strobes(strobes),
    .newFlags(newFlags)
  );
endmodule

// File: rtl/flag_gen_checker.sv
module flag_gen_checker #(
  parameter int DATA_W  = 64,
  parameter int FLAG_W  = 64,
  parameter int CF_POS  = 0,
  parameter int PF_POS  = 2,
  parameter int ZF_POS  = 6,
  parameter int SF_POS  = 7,
  parameter int ECF_POS = 16,
  parameter int EZF_POS = 17
) (
  input logic [FLAG_W-1:0] oldFlags,
  input logic [FLAG_W-1:0] flagMask,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] newFlags
);
  always_comb begin
    p_keep_unmasked_r1: assert (((newFlags ^ oldFlags) & ~flagMask) == '0)
      else $error("unmasked flag bit changed");
    if (flagMask[PF_POS])
      p_parity_low_byte_r5: assert (newFlags[PF_POS] == ~^result[7:0])
        else $error("parity mismatch");
    if (flagMask[CF_POS] && flagMask[ECF_POS])
      p_ecf_mirror_r9: assert (newFlags[CF_POS] == newFlags[ECF_POS])
        else $error("emulation carry differs from carry");
    if (flagMask[ZF_POS] && flagMask[EZF_POS])
      p_ezf_mirror_r9: assert (newFlags[ZF_POS] == newFlags[EZF_POS])
        else $error("emulation zero differs from zero");
    if (flagMask[ZF_POS] && flagMask[SF_POS])
      p_zero_not_neg_r7: assert (!(newFlags[ZF_POS] && newFlags[SF_POS]))
        else $error("zero and sign both set");
  end
endmodule

bind flag_gen flag_gen_checker #(
  .DATA_W(DATA_W), .FLAG_W(FLAG_W), .CF_POS(CF_POS), .PF_POS(PF_POS),
  .ZF_POS(ZF_POS), .SF_POS(SF_POS), .ECF_POS(ECF_POS), .EZF_POS(EZF_POS)
) uChk (
  .oldFlags(oldFlags),
  .flagMask(flagMask),
  .result(result),
  .newFlags(newFlags)
);

// File: tb/flag_gen_test.sv
module flag_gen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] oldFlags, flagMask, result, src1, src2, newFlags;
  logic [1:0]  sizeCode;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  flag_gen uut (
    .oldFlags(oldFlags), .flagMask(flagMask), .result(result),
    .src1(src1), .src2(src2), .sizeCode(sizeCode), .newFlags(newFlags)
  );

  localparam logic [63:0] ALLF = 64'h3_08D5;

  function automatic logic [63:0] refFlags(input logic [63:0] o, m, d, a, b,
                                            input logic [1:0] sz);
    int w = 8 << sz;
    logic [63:0] lim = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic dt = d[w-1], at = a[w-1], bt = b[w-1];
    logic c = (at & bt) | ((at | bt) & ~dt);
    logic ac = (a[3] & b[3]) | ((a[3] | b[3]) & ~d[3]);
    logic z = ((d & lim) == 0);
    int ones = $countones(d[7:0]);
    logic p = (ones % 2) == 0;
    logic v = (at == bt) && (dt != at);
    logic [63:0] r = o & ~m;
    r[0]  = m[0]  ? c  : r[0];
    r[2]  = m[2]  ? p  : r[2];
    r[4]  = m[4]  ? ac : r[4];
    r[6]  = m[6]  ? z  : r[6];
    r[7]  = m[7]  ? dt : r[7];
    r[11] = m[11] ? v  : r[11];
    r[16] = m[16] ? c  : r[16];
    r[17] = m[17] ? z  : r[17];
    return r;
  endfunction

  task automatic apply(input logic [63:0] o, m, d, a, b, input logic [1:0] sz);
    @(posedge clk);
    oldFlags = o; flagMask = m; result = d; src1 = a; src2 = b; sizeCode = sz;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    oldFlags = '0; flagMask = '0; result = '0; src1 = '0; src2 = '0; sizeCode = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle all-zero", newFlags, 64'h0);

    apply('1, '0, 64'h1234, 64'h1, 64'h2, 2'd3);
    check("R1 empty mask keeps old", newFlags, '1);

    apply('1, ALLF, 64'h0, 64'h0, 64'h0, 2'd3);
    check("R2 masked cleared then set", newFlags, ~ALLF | 64'h2_0044);

    apply('0, 64'h100, 64'h0, 64'h0, 64'h0, 2'd0);
    check("R2 non-flag masked bit zero", newFlags, 64'h0);

    apply('0, ALLF, 64'h100, 64'hFF, 64'h01, 2'd0);
    check("R3 byte carry", newFlags[0], 1'b1);
    check("R4 nibble carry", newFlags[4], 1'b1);
    check("R6 byte zero truncated", newFlags[6], 1'b1);
    check("R5 parity of zero byte", newFlags[2], 1'b1);
    check("R9 ecf/ezf mirror", newFlags[17:16], 2'b11);

    apply('0, ALLF, 64'h100, 64'hFF, 64'h01, 2'd1);
    check("R10 word no carry/zero", {62'd0, newFlags[6], newFlags[0]}, 64'h0);

    apply('0, ALLF, 64'h80, 64'h7F, 64'h01, 2'd0);
    check("R8 signed overflow byte", newFlags[11], 1'b1);
    check("R7 sign byte", newFlags[7], 1'b1);
    check("R5 parity odd", newFlags[2], 1'b0);

    apply('0, ALLF, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'd3);
    check("R8 overflow quad", newFlags[11], 1'b1);
    check("R7 sign quad", newFlags[7], 1'b1);

    apply('0, 64'h1_0000, 64'h0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 2'd2);
    check("R9 ecf only", newFlags, 64'h1_0000);

    apply('0, ALLF, 64'hABCD_0000_0000, 64'h0, 64'h0, 2'd2);
    check("R10 upper bits ignored zero", newFlags[6], 1'b1);

    for (int i = 0; i < 600; i++) begin
      logic [63:0] o = {$urandom, $urandom};
      logic [63:0] m = {$urandom, $urandom};
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [63:0] d = ($urandom % 2) ? a + b : {$urandom, $urandom};
      logic [1:0]  s = 2'($urandom % 4);
      apply(o, m, d, a, b, s);
      check("R2 random", newFlags, refFlags(o, m, d, a, b, s));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule